// File: doc/BRIEF.md
# Dual-Channel Block-Buffered Sample Mixer

This block merges two independent 8-bit sample streams, for example background music and spoken announcements, into one output stream for a DAC. Each channel's samples lie at consecutive addresses in a byte-wide sequential memory. The block reads a burst from each channel and sums them into a block buffer. A second block buffer is played out at the same time. The memory only needs an address when a burst starts. After that, every request returns the next byte.

There are two banks of `BLK` samples each. While one bank plays at the sample rate, the fill sequencer handles the other bank in two passes. The first pass copies `BLK` bytes of channel A into the bank. The second pass reads `BLK` bytes of channel B and adds each one in place, using offset-binary arithmetic with saturation. When the last sample of a block plays, the banks swap, provided the fill has finished. If the fill has not finished, the block raises a sticky underrun flag and plays the same bank again. Samples are unsigned offset binary, so 0x80 is the zero level. A disabled channel adds that zero level.

Top module: `pingpong_mixer`

## Requirements
- R1: While `run` is low, and after reset, `smp_out` is 0x80, and `smp_tick`, `mem_req` and `underrun` are all 0.
- R2: While `run` is high, `smp_tick` pulses for one clock every `TICK_DIV` clocks. `smp_out` changes only in a cycle where `smp_tick` is high.
- R3: The first `BLK` samples after `run` rises are the zero level 0x80.
- R4: Each fill reads channel A first and then channel B. Fill k of a run reads, for each channel, one request with `mem_load`=1 at that channel's start address + k*`BLK`, followed by `BLK`-1 requests with `mem_load`=0. That is `2*BLK` requests in total. Each `mem_req` lasts one clock, and the next request waits for `mem_rvalid`.
- R5: Each output sample equals clamp(a + b - 128, 0, 255), where a and b are the unsigned bytes at the same index of the two channels' bursts.
- R6: When a channel's enable is low, its bytes are still read, but it contributes 0x80, so the output equals the other channel's byte.
- R7: When every fill finishes within one block period, output block k+1 (k ≥ 0) holds chunk k of each channel and `underrun` stays 0.
- R8: If a fill has not finished when a block's last sample plays, `underrun` is set and stays set. The bank that just played is repeated, and the banks swap at the first block end after the fill completes.
- R9: Dropping `run` clears `underrun`. The next rise of `run` restarts both channels from their start-address inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables playout and filling; low holds the block idle |
| chan_a_en | input | 1 | Channel A contributes its samples when high |
| chan_b_en | input | 1 | Channel B contributes its samples when high |
| chan_a_base | input | ADDR_W | Channel A start address, taken while `run` is low |
| chan_b_base | input | ADDR_W | Channel B start address, taken while `run` is low |
| mem_req | output | 1 | One-clock byte read request |
| mem_load | output | 1 | With `mem_req`: load `mem_addr` before reading |
| mem_addr | output | ADDR_W | Read address (used by memory when `mem_load` is set) |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| smp_out | output | 8 | Mixed output sample, offset binary |
| smp_tick | output | 1 | One-clock pulse when a new sample is presented |
| underrun | output | 1 | Sticky: a block end found the fill incomplete |

## Verification
The bench builds the block with `BLK`=8, `TICK_DIV`=12 and `ADDR_W`=16. A block period is then 96 clocks, so several swaps fit in a short run. The bench's memory model answers after a latency it can set. With a 2-clock latency a fill takes 48 clocks and always keeps up. With a 6-clock latency a fill takes about 112 clocks, which forces the repeat-and-late-swap pattern on every block. The channel bases are multiples of 16 and the memory contents are chosen by address, so both saturation limits are reached within the first chunk.

// File: rtl/mixer_pkg.sv
`timescale 1ns/1ps
package mixer_pkg;

    localparam int SMP_W = 8;
    localparam logic [SMP_W-1:0] SMP_MID = {1'b1, {(SMP_W-1){1'b0}}};

    localparam logic [SMP_W:0] SUM_LO = {1'b0, SMP_MID};
    localparam logic [SMP_W:0] SUM_HI = SUM_LO + {1'b0, {SMP_W{1'b1}}};

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_REQ,
        FS_WAIT
    } fill_state_e;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;

    typedef struct packed {
        logic             en;
        logic             add;
        logic             bank;
        logic [SMP_W-1:0] data;
    } buf_wr_t;

    // Offset-binary sum: (a-mid)+(b-mid) saturated, re-offset by mid.
    function automatic logic [SMP_W-1:0] mix_sat(input logic [SMP_W-1:0] a,
                                                 input logic [SMP_W-1:0] b);
        logic [SMP_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s < SUM_LO)
            return '0;
        else if (s > SUM_HI)
            return '1;
        else
            return SMP_W'(s - SUM_LO);
    endfunction

endpackage

// File: rtl/mix_tick_gen.sv
`timescale 1ns/1ps
module mix_tick_gen #(
    parameter int TICK_DIV = 31250
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/mix_buffer.sv
`timescale 1ns/1ps
module mix_buffer
    import mixer_pkg::*;
#(
    parameter int BLK   = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  buf_wr_t          wr,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             rd_bank,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [SMP_W-1:0] rd_data
);
    logic [SMP_W-1:0] bank_rd [2];

    for (genvar gb = 0; gb < 2; gb++) begin : g_bank
        logic [SMP_W-1:0] store [BLK];
        logic             hit;

        assign hit = wr.en && (wr.bank == 1'(gb));

        always_ff @(posedge clk) begin
            if (hit) begin
                if (wr.add)
                    store[wr_idx] <= mix_sat(store[wr_idx], wr.data);
                else
                    store[wr_idx] <= wr.data;
            end
        end

        assign bank_rd[gb] = store[rd_idx];
    end

    assign rd_data = rd_bank ? bank_rd[1] : bank_rd[0];
endmodule

// File: rtl/mix_fill.sv
`timescale 1ns/1ps
module mix_fill
    import mixer_pkg::*;
#(
    parameter int BLK    = 64,
    parameter int IDX_W  = 6,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              go,
    input  logic              fill_bank,
    input  logic              chan_a_en,
    input  logic              chan_b_en,
    input  logic [ADDR_W-1:0] chan_a_base,
    input  logic [ADDR_W-1:0] chan_b_base,
    output logic              mem_req,
    output logic              mem_load,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [SMP_W-1:0]  mem_rdata,
    output buf_wr_t           wr,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              done
);
    localparam logic [IDX_W-1:0]  LAST = IDX_W'(BLK - 1);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BLK);

    fill_state_e       state;
    chan_e             ch;
    logic [IDX_W-1:0]  cnt;
    logic [ADDR_W-1:0] ptr_a;
    logic [ADDR_W-1:0] ptr_b;
    logic              beat;
    logic              ch_on;

    assign beat  = (state == FS_WAIT) && mem_rvalid;
    assign ch_on = (ch == CH_A) ? chan_a_en : chan_b_en;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state <= FS_IDLE;
            ch    <= CH_A;
            cnt   <= '0;
            done  <= 1'b0;
            ptr_a <= chan_a_base;
            ptr_b <= chan_b_base;
        end else if (go) begin
            state <= FS_REQ;
            ch    <= CH_A;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            unique case (state)
                FS_REQ:  state <= FS_WAIT;
                FS_WAIT: begin
                    if (mem_rvalid) begin
                        if (cnt == LAST) begin
                            cnt <= '0;
                            if (ch == CH_A) begin
                                ch    <= CH_B;
                                state <= FS_REQ;
                            end else begin
                                state <= FS_IDLE;
                                done  <= 1'b1;
                                ptr_a <= ptr_a + STEP;
                                ptr_b <= ptr_b + STEP;
                            end
                        end else begin
                            cnt   <= cnt + 1'b1;
                            state <= FS_REQ;
                        end
                    end
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    assign mem_req  = (state == FS_REQ);
    assign mem_load = (cnt == '0);
    assign mem_addr = ((ch == CH_A) ? ptr_a : ptr_b) + ADDR_W'(cnt);

    assign wr.en   = beat;
    assign wr.add  = (ch == CH_B);
    assign wr.bank = fill_bank;
    assign wr.data = ch_on ? mem_rdata : SMP_MID;
    assign wr_idx  = cnt;
endmodule

// File: rtl/mix_play.sv
`timescale 1ns/1ps
module mix_play
    import mixer_pkg::*;
#(
    parameter int BLK   = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             fill_done,
    input  logic [SMP_W-1:0] rd_data,
    output logic             play_bank,
    output logic [IDX_W-1:0] play_idx,
    output logic             swap,
    output logic [SMP_W-1:0] smp_out,
    output logic             smp_tick,
    output logic             underrun
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BLK - 1);

    logic play_valid;
    logic blk_end;

    assign blk_end = tick && (play_idx == LAST);
    assign swap    = blk_end && fill_done;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            play_bank  <= 1'b1;
            play_idx   <= '0;
            play_valid <= 1'b0;
            underrun   <= 1'b0;
            smp_out    <= SMP_MID;
            smp_tick   <= 1'b0;
        end else begin
            smp_tick <= tick;
            if (tick) begin
                smp_out  <= play_valid ? rd_data : SMP_MID;
                play_idx <= (play_idx == LAST) ? '0 : play_idx + 1'b1;
            end
            if (swap) begin
                play_bank  <= ~play_bank;
                play_valid <= 1'b1;
            end else if (blk_end) begin
                underrun <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pingpong_mixer.sv
`timescale 1ns/1ps
module pingpong_mixer
    import mixer_pkg::*;
#(
    parameter int BLK      = 64,
    parameter int ADDR_W   = 20,
    parameter int TICK_DIV = 31250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              chan_a_en,
    input  logic              chan_b_en,
    input  logic [ADDR_W-1:0] chan_a_base,
    input  logic [ADDR_W-1:0] chan_b_base,
    output logic              mem_req,
    output logic              mem_load,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        smp_out,
    output logic              smp_tick,
    output logic              underrun
);
    localparam int IDX_W = (BLK > 1) ? $clog2(BLK) : 1;

    logic             tick;
    logic             run_q;
    logic             fill_go;
    logic             swap;
    logic             fill_done;
    logic             play_bank;
    logic [IDX_W-1:0] play_idx;
    logic [SMP_W-1:0] rd_data;
    buf_wr_t          wr;
    logic [IDX_W-1:0] wr_idx;

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= 1'b0;
        else
            run_q <= run;
    end

    assign fill_go = (run && !run_q) || swap;

    mix_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    mix_fill #(.BLK(BLK), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_fill (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .go          (fill_go),
        .fill_bank   (~play_bank),
        .chan_a_en   (chan_a_en),
        .chan_b_en   (chan_b_en),
        .chan_a_base (chan_a_base),
        .chan_b_base (chan_b_base),
        .mem_req     (mem_req),
        .mem_load    (mem_load),
        .mem_addr    (mem_addr),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .wr          (wr),
        .wr_idx      (wr_idx),
        .done        (fill_done)
    );

    mix_buffer #(.BLK(BLK), .IDX_W(IDX_W)) u_buf (
        .clk     (clk),
        .wr      (wr),
        .wr_idx  (wr_idx),
        .rd_bank (play_bank),
        .rd_idx  (play_idx),
        .rd_data (rd_data)
    );

    mix_play #(.BLK(BLK), .IDX_W(IDX_W)) u_play (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .tick      (tick),
        .fill_done (fill_done),
        .rd_data   (rd_data),
        .play_bank (play_bank),
        .play_idx  (play_idx),
        .swap      (swap),
        .smp_out   (smp_out),
        .smp_tick  (smp_tick),
        .underrun  (underrun)
    );
endmodule

// File: rtl/mixer_checks.sv
`timescale 1ns/1ps
module mixer_checks (
    input logic       clk,
    input logic       rst,
    input logic       run,
    input logic       mem_req,
    input logic       smp_tick,
    input logic [7:0] smp_out,
    input logic       underrun
);
    // R1: low run leaves no tick and no request in the next cycle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!smp_tick && !mem_req));

    // R2: sample pulse lasts one clock
    p_tick_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        smp_tick |=> !smp_tick);

    // R2: output holds between pulses while running
    p_hold_between_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && !smp_tick) |-> $stable(smp_out));

    // R4: one request at a time, never back to back
    p_req_single_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R8: underrun is sticky while running
    p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (underrun && run) |=> underrun);

    // R9: dropping run clears underrun
    p_underrun_clear_r9: assert property (@(posedge clk) disable iff (rst)
        !run |=> !underrun);
endmodule

bind pingpong_mixer mixer_checks u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .mem_req  (mem_req),
    .smp_tick (smp_tick),
    .smp_out  (smp_out),
    .underrun (underrun)
);

// File: tb/sim_pingpong_mixer.sv
`timescale 1ns/1ps
module sim_pingpong_mixer;
    localparam int BLK      = 8;
    localparam int ADDR_W   = 16;
    localparam int TICK_DIV = 12;
    localparam int WDOG     = 150000;

    typedef struct {
        int    val;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              run = 1'b0;
    logic              chan_a_en = 1'b1;
    logic              chan_b_en = 1'b1;
    logic [ADDR_W-1:0] chan_a_base = '0;
    logic [ADDR_W-1:0] chan_b_base = '0;
    logic              mem_req;
    logic              mem_load;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [7:0]        mem_rdata = '0;
    logic [7:0]        smp_out;
    logic              smp_tick;
    logic              underrun;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   cyc      = 0;
    int   lat      = 2;
    int   pend     = 0;
    int   cur_addr = 0;
    int   last_tick = -1;
    int   rd_cnt   = 0;
    bit   first_load = 1'b1;
    exp_t exp_q[$];
    int   load_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pingpong_mixer #(.BLK(BLK), .ADDR_W(ADDR_W), .TICK_DIV(TICK_DIV)) u0 (
        .clk(clk), .rst(rst), .run(run),
        .chan_a_en(chan_a_en), .chan_b_en(chan_b_en),
        .chan_a_base(chan_a_base), .chan_b_base(chan_b_base),
        .mem_req(mem_req), .mem_load(mem_load), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .smp_out(smp_out), .smp_tick(smp_tick), .underrun(underrun)
    );

    function automatic int memv(int a);
        case (a & 15)
            0:       return 255;
            1:       return 0;
            2:       return 128;
            default: return (a * 29 + (a >> 4) * 7 + 5) & 255;
        endcase
    endfunction

    function automatic int mixref(int a, int b);
        int s;
        s = a + b - 128;
        if (s < 0) return 0;
        if (s > 255) return 255;
        return s;
    endfunction

    task automatic chk(string req, bit ok, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // memory model and monitors
    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = 8'(memv(cur_addr));
                    cur_addr++;
                end
            end
            if (mem_req) begin
                if (mem_load) begin
                    // R4: load address order and burst length
                    if (!first_load)
                        chk("R4 burst length", rd_cnt == BLK, rd_cnt, BLK);
                    first_load = 1'b0;
                    rd_cnt = 1;
                    if (load_q.size() > 0) begin
                        int e;
                        e = load_q.pop_front();
                        chk("R4 load address", int'(mem_addr) == e, int'(mem_addr), e);
                    end
                    cur_addr = int'(mem_addr);
                end else begin
                    rd_cnt++;
                end
                pend = lat;
            end
            if (smp_tick) begin
                if (last_tick >= 0)
                    chk("R2 tick spacing", cyc - last_tick == TICK_DIV, cyc - last_tick, TICK_DIV);
                last_tick = cyc;
                if (exp_q.size() == 0) begin
                    chk("R1 unexpected sample", 1'b0, int'(smp_out), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(e.tag, int'(smp_out) == e.val, int'(smp_out), e.val);
                end
            end
            if (cyc > WDOG) begin
                chk("watchdog", 1'b0, cyc, WDOG);
                report();
            end
        end
    end

    // driver: pushes expected samples and load addresses, then runs
    task automatic run_case(bit ea, bit eb, int l, int ba, int bb, int nblk, bit slow);
        int guard;
        chan_a_en   = ea;
        chan_b_en   = eb;
        chan_a_base = ADDR_W'(ba);
        chan_b_base = ADDR_W'(bb);
        lat         = l;
        pend        = 0;
        first_load  = 1'b1;
        last_tick   = -1;
        exp_q.delete();
        load_q.delete();
        for (int k = 0; k < nblk + 2; k++) begin
            load_q.push_back(ba + k * BLK);
            load_q.push_back(bb + k * BLK);
        end
        for (int b = 0; b < nblk; b++) begin
            int chunk;
            string tg;
            if (slow) chunk = (b < 2) ? -1 : (b - 2) / 2;
            else      chunk = b - 1;
            for (int i = 0; i < BLK; i++) begin
                exp_t e;
                int av, bv;
                if (chunk < 0) begin
                    e.val = 128;
                    e.tag = slow ? "R8 replay silence" : "R3 first block silence";
                end else begin
                    av = ea ? memv(ba + chunk * BLK + i) : 128;
                    bv = eb ? memv(bb + chunk * BLK + i) : 128;
                    e.val = mixref(av, bv);
                    if (slow)          tg = "R8 late swap";
                    else if (!ea || !eb) tg = "R6 disabled channel";
                    else if (i < 2)    tg = "R5 saturating mix";
                    else               tg = "R7 block order";
                    e.tag = tg;
                end
                exp_q.push_back(e);
            end
        end
        @(negedge clk);
        run = 1'b1;
        guard = 0;
        while (exp_q.size() > 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk("R7/R8 queue drained", exp_q.size() == 0, exp_q.size(), 0);
        if (slow) chk("R8 underrun set", underrun == 1'b1, int'(underrun), 1);
        else      chk("R7 no underrun", underrun == 1'b0, int'(underrun), 0);
        run = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 underrun cleared", underrun == 1'b0, int'(underrun), 0);
        chk("R1 idle output", smp_out == 8'h80, int'(smp_out), 128);
        chk("R1 idle request", mem_req == 1'b0, int'(mem_req), 0);
        repeat (2 * TICK_DIV) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 reset output", smp_out == 8'h80, int'(smp_out), 128);
        chk("R1 reset tick", smp_tick == 1'b0, int'(smp_tick), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset request", mem_req == 1'b0, int'(mem_req), 0);
        chk("R1 reset underrun", underrun == 1'b0, int'(underrun), 0);

        run_case(1'b1, 1'b1, 2, 'h100, 'h800, 5, 1'b0);
        // R9: new bases taken on restart
        run_case(1'b0, 1'b1, 2, 'h300, 'h540, 3, 1'b0);
        run_case(1'b1, 1'b0, 2, 'h200, 'h600, 3, 1'b0);
        run_case(1'b1, 1'b1, 6, 'h100, 'h800, 6, 1'b1);
        // R9: restart after underrun begins again from the bases
        run_case(1'b1, 1'b1, 2, 'h100, 'h800, 3, 1'b0);
        report();
    end
endmodule